// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Selectable Read Latency

This block is a true dual-port synchronous memory. Each port has its own clock and registers its address, its read/write control, its two select inputs and its write data on the rising edge of that clock. Both ports may read or write any word at any time, independently of each other. Depth and word width are parameters.

Each port has a static mode input. In flow-through mode, read data appears in the same cycle as the edge that captured the address. In pipelined mode, the data passes through one more output register and appears one cycle later. Each port has two select inputs of opposite polarity and an output enable. Tristate output is modelled with a per-port drive flag. While the flag is low, the data output is held at zero. If both ports write the same word in the same period, the stored value is undefined.

Each port runs two small state machines.

The access register has three states:
- `ACC_IDLE` is entered on any capture edge where the port is not selected.
- `ACC_READ` is entered when the port is selected and `wr_n` is high.
- `ACC_WRITE` is entered when the port is selected and `wr_n` is low. A word is committed at the port's next edge while in this state.

The pipelined output stage has two states:
- `POUT_LIVE` is entered on an edge where the access state is `ACC_READ`.
- `POUT_BLANK` is entered on every other edge.

Top module: `dpr_sync_ram`

## Requirements
- R1: While `rst_n` is low, and after its release until a read is captured, both drive flags are 0 and both data outputs are all zeros.
- R2: A port is selected when its `cs_n` is 0 and its `cs` is 1. A cycle captured while selected with `wr_n` = 0 stores `wdata` at `addr`, and a later read of that address returns it.
- R3: With `pipe` = 0, a read captured at an edge drives its data (drive flag 1) from that edge until the next edge.
- R4: With `pipe` = 1, a read captured at an edge drives its data only after the following edge. Between the capturing edge and that following edge, the output still reflects the previous cycle.
- R5: On every other select combination (`cs_n`,`cs` = 1,1 or 0,0 or 1,0), no word is written and the port does not drive.
- R6: A deselect blanks the output at a clock edge. In flow-through mode this is the edge that captures the deselect. In pipelined mode it is the edge after that, and until then the previous read's data stays driven.
- R7: In pipelined mode, after a blank period the output drives again only after one selected read cycle has passed through the output register.
- R8: The output enable acts without a clock. While `oe_n` is 1, the drive flag is 0 and the data is zero. Lowering `oe_n` mid-cycle restores the pending read data at once.
- R9: Both ports may write different addresses in overlapping cycles on their own clocks. Both words are stored, and each is readable from the other port.
- R10: A write cycle never drives the data output.
- R11: A write commits at the writing port's edge after its capture. A read by the other port of that word, made before the commit, returns the old value.
- R12: The mode is per port. One port pipelined and the other flow-through, reading at the same time, each show their own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both ports |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A control: 0 write, 1 read |
| a_oe_n | input | 1 | Port A output enable, active low, unclocked |
| a_pipe | input | 1 | Port A mode: 1 pipelined, 0 flow-through |
| a_addr | input | AW | Port A word address |
| a_wdata | input | WIDTH | Port A write data |
| a_rdata | output | WIDTH | Port A read data, zero when not driven |
| a_drive | output | 1 | Port A data-driven flag |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B control: 0 write, 1 read |
| b_oe_n | input | 1 | Port B output enable, active low, unclocked |
| b_pipe | input | 1 | Port B mode: 1 pipelined, 0 flow-through |
| b_addr | input | AW | Port B word address |
| b_wdata | input | WIDTH | Port B write data |
| b_rdata | output | WIDTH | Port B read data, zero when not driven |
| b_drive | output | 1 | Port B data-driven flag |

## Verification
Timing of each result:
- A flow-through read is due right after its capturing edge. The bench samples it half a period later, at the falling edge, before the next rising edge.
- A pipelined read is due one full cycle later. The bench samples it at the falling edge after the next capture, and also checks that the earlier falling edge still shows the previous state.
- The output enable is combinational. The bench checks it 1 ns after changing it, within the same cycle.
- The cross-port commit check uses port B's clock, which lags port A's by 3 ns. A read on B sampled before A's commit edge must show the old word. The next B read must show the new word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // State of the access captured at the last port clock edge
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // State of the pipelined output register
    typedef enum logic {
        POUT_BLANK = 1'b0,
        POUT_LIVE  = 1'b1
    } pout_e;

endpackage

// File: rtl/dpr_xor_array.sv
// Two-port storage built from two banks, each written by one clock only.
// A word is the XOR of both banks; a writer stores data XOR the other bank.
module dpr_xor_array #(
    parameter int DEPTH = 256,
    parameter int DW    = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk_a,
    input  logic          we_a,
    input  logic [AW-1:0] addr_a,
    input  logic [DW-1:0] wd_a,
    output logic [DW-1:0] rd_a,
    input  logic          clk_b,
    input  logic          we_b,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] wd_b,
    output logic [DW-1:0] rd_b
);

    logic [DW-1:0] bank_a [DEPTH];
    logic [DW-1:0] bank_b [DEPTH];

    always_ff @(posedge clk_a) begin
        if (we_a) begin
            bank_a[addr_a] <= wd_a ^ bank_b[addr_a];
        end
    end

    always_ff @(posedge clk_b) begin
        if (we_b) begin
            bank_b[addr_b] <= wd_b ^ bank_a[addr_b];
        end
    end

    always_comb begin
        rd_a = bank_a[addr_a] ^ bank_b[addr_a];
        rd_b = bank_a[addr_b] ^ bank_b[addr_b];
    end

endmodule

// File: rtl/dpr_port_ctrl.sv
// One port: input capture, access state machine and output stage.
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cs,
    input  logic          wr_n,
    input  logic          oe_n,
    input  logic          pipe_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] arr_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic [DW-1:0] rdata,
    output logic          rd_drive
);

    acc_e          acc_q, acc_d;
    pout_e         pout_q, pout_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] pdata_q;
    logic          sel_in;
    logic          stage_live;
    logic [DW-1:0] stage_data;

    assign sel_in = !cs_n && cs;

    // Next access state from the inputs being captured
    always_comb begin
        unique case ({sel_in, wr_n})
            2'b10:   acc_d = ACC_WRITE;
            2'b11:   acc_d = ACC_READ;
            default: acc_d = ACC_IDLE;
        endcase
    end

    // Next output-register state from the current access
    always_comb begin
        unique case (acc_q)
            ACC_READ: pout_d = POUT_LIVE;
            default:  pout_d = POUT_BLANK;
        endcase
    end

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= ACC_IDLE;
            pout_q  <= POUT_BLANK;
            addr_q  <= '0;
            wdata_q <= '0;
            pdata_q <= '0;
        end else begin
            acc_q   <= acc_d;
            pout_q  <= pout_d;
            addr_q  <= addr;
            wdata_q <= wdata;
            if (acc_q == ACC_READ) begin
                pdata_q <= rd_word;
            end
        end
    end

    // Outputs
    always_comb begin
        arr_addr = addr_q;
        wr_data  = wdata_q;
        wr_en    = (acc_q == ACC_WRITE);
        unique case (pipe_en)
            1'b1: begin
                stage_live = (pout_q == POUT_LIVE);
                stage_data = pdata_q;
            end
            default: begin
                stage_live = (acc_q == ACC_READ);
                stage_data = rd_word;
            end
        endcase
        rd_drive = stage_live && !oe_n;
        rdata    = rd_drive ? stage_data : '0;
    end

    // Flow-through drive only follows a selected read capture
    assert_flow_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_en && rd_drive) |-> $past(sel_in && wr_n));

    // Memory write only after a selected write capture
    assert_write_needs_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(sel_in && !wr_n));

    // Flow-through deselect blanks at the capturing edge
    assert_flow_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_en && !sel_in) |=> (pipe_en || !rd_drive));

    // Pipelined deselect blanks one edge later
    assert_pipe_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && !sel_in) ##1 pipe_en |=> (!pipe_en || !rd_drive));

    // Pipelined output returns only after a selected read two edges back
    assert_pipe_reactivate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && $past(pipe_en) && !oe_n && $past(!oe_n) && $rose(rd_drive))
        |-> $past(sel_in && wr_n, 2));

endmodule

// File: rtl/dpr_sync_ram.sv
module dpr_sync_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic             a_cs_n,
    input  logic             a_cs,
    input  logic             a_wr_n,
    input  logic             a_oe_n,
    input  logic             a_pipe,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    output logic             a_drive,
    input  logic             b_cs_n,
    input  logic             b_cs,
    input  logic             b_wr_n,
    input  logic             b_oe_n,
    input  logic             b_pipe,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata,
    output logic             b_drive
);

    logic [AW-1:0]    arr_addr_a, arr_addr_b;
    logic             we_a, we_b;
    logic [WIDTH-1:0] wd_a, wd_b;
    logic [WIDTH-1:0] word_a, word_b;

    dpr_port_ctrl #(.AW(AW), .DW(WIDTH)) u_port_a (
        .clk      (clk_a),
        .rst_n    (rst_n),
        .cs_n     (a_cs_n),
        .cs       (a_cs),
        .wr_n     (a_wr_n),
        .oe_n     (a_oe_n),
        .pipe_en  (a_pipe),
        .addr     (a_addr),
        .wdata    (a_wdata),
        .rd_word  (word_a),
        .arr_addr (arr_addr_a),
        .wr_en    (we_a),
        .wr_data  (wd_a),
        .rdata    (a_rdata),
        .rd_drive (a_drive)
    );

    dpr_port_ctrl #(.AW(AW), .DW(WIDTH)) u_port_b (
        .clk      (clk_b),
        .rst_n    (rst_n),
        .cs_n     (b_cs_n),
        .cs       (b_cs),
        .wr_n     (b_wr_n),
        .oe_n     (b_oe_n),
        .pipe_en  (b_pipe),
        .addr     (b_addr),
        .wdata    (b_wdata),
        .rd_word  (word_b),
        .arr_addr (arr_addr_b),
        .wr_en    (we_b),
        .wr_data  (wd_b),
        .rdata    (b_rdata),
        .rd_drive (b_drive)
    );

    dpr_xor_array #(.DEPTH(DEPTH), .DW(WIDTH)) u_array (
        .clk_a  (clk_a),
        .we_a   (we_a),
        .addr_a (arr_addr_a),
        .wd_a   (wd_a),
        .rd_a   (word_a),
        .clk_b  (clk_b),
        .we_b   (we_b),
        .addr_b (arr_addr_b),
        .wd_b   (wd_b),
        .rd_b   (word_b)
    );

endmodule

// File: tb/tb_dpr_sync_ram.sv
module tb_dpr_sync_ram;

    localparam int AW = 8;
    localparam int DW = 9;

    logic clk_a, clk_b, rst_n;
    logic a_cs_n, a_cs, a_wr_n, a_oe_n, a_pipe;
    logic b_cs_n, b_cs, b_wr_n, b_oe_n, b_pipe;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic a_drive, b_drive;

    int n_chk  = 0;
    int n_fail = 0;

    dpr_sync_ram dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_cs(a_cs), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n),
        .a_pipe(a_pipe), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_drive(a_drive),
        .b_cs_n(b_cs_n), .b_cs(b_cs), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n),
        .b_pipe(b_pipe), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_drive(b_drive)
    );

    // 100 MHz clocks; port B lags port A by 3 ns
    initial clk_a = 1'b0;
    always #5 clk_a = ~clk_a;
    initial begin
        clk_b = 1'b0;
        #3;
        forever #5 clk_b = ~clk_b;
    end

    task automatic chk(input string tag, input logic en_act, input logic [DW-1:0] d_act,
                       input logic en_exp, input logic [DW-1:0] d_exp);
        n_chk++;
        if (en_act !== en_exp || d_act !== d_exp) begin
            n_fail++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     tag, en_act, d_act, en_exp, d_exp);
        end
    endtask

    task automatic a_cyc(input logic cs_n, input logic cs, input logic wr_n,
                         input logic [AW-1:0] ad, input logic [DW-1:0] wd);
        a_cs_n = cs_n; a_cs = cs; a_wr_n = wr_n; a_addr = ad; a_wdata = wd;
        @(posedge clk_a);
        @(negedge clk_a);
    endtask

    task automatic b_cyc(input logic cs_n, input logic cs, input logic wr_n,
                         input logic [AW-1:0] ad, input logic [DW-1:0] wd);
        b_cs_n = cs_n; b_cs = cs; b_wr_n = wr_n; b_addr = ad; b_wdata = wd;
        @(posedge clk_b);
        @(negedge clk_b);
    endtask

    task automatic a_rd(input logic [AW-1:0] ad);  a_cyc(1'b0, 1'b1, 1'b1, ad, '0); endtask
    task automatic a_wr(input logic [AW-1:0] ad, input logic [DW-1:0] wd); a_cyc(1'b0, 1'b1, 1'b0, ad, wd); endtask
    task automatic a_idle();                        a_cyc(1'b1, 1'b0, 1'b1, '0, '0); endtask
    task automatic b_rd(input logic [AW-1:0] ad);  b_cyc(1'b0, 1'b1, 1'b1, ad, '0); endtask
    task automatic b_wr(input logic [AW-1:0] ad, input logic [DW-1:0] wd); b_cyc(1'b0, 1'b1, 1'b0, ad, wd); endtask
    task automatic b_idle();                        b_cyc(1'b1, 1'b0, 1'b1, '0, '0); endtask

    task automatic t_reset();
        a_cs_n = 1; a_cs = 0; a_wr_n = 1; a_oe_n = 0; a_pipe = 0; a_addr = '0; a_wdata = '0;
        b_cs_n = 1; b_cs = 0; b_wr_n = 1; b_oe_n = 0; b_pipe = 0; b_addr = '0; b_wdata = '0;
        rst_n = 1'b0;
        #32;
        chk("R1 port A in reset", a_drive, a_rdata, 1'b0, '0);
        chk("R1 port B in reset", b_drive, b_rdata, 1'b0, '0);
        @(negedge clk_a);
        rst_n = 1'b1;
        a_idle();
        b_idle();
        chk("R1 port A after release", a_drive, a_rdata, 1'b0, '0);
        chk("R1 port B after release", b_drive, b_rdata, 1'b0, '0);
    endtask

    task automatic t_flow();
        a_wr(8'h10, 9'h155);
        chk("R10 write cycle does not drive", a_drive, a_rdata, 1'b0, '0);
        a_wr(8'h11, 9'h0AA);
        a_rd(8'h10);
        chk("R3 flow read same cycle", a_drive, a_rdata, 1'b1, 9'h155);
        a_rd(8'h11);
        chk("R2 stored word read back", a_drive, a_rdata, 1'b1, 9'h0AA);
        a_idle();
        chk("R6 flow deselect blanks at capture edge", a_drive, a_rdata, 1'b0, '0);
    endtask

    task automatic t_pipe();
        a_pipe = 1'b1;
        a_idle();
        a_rd(8'h10);
        chk("R4 pipelined not yet driven", a_drive, a_rdata, 1'b0, '0);
        a_rd(8'h11);
        chk("R4 pipelined first word one cycle later", a_drive, a_rdata, 1'b1, 9'h155);
        a_idle();
        chk("R6 pipelined deselect keeps previous read", a_drive, a_rdata, 1'b1, 9'h0AA);
        a_idle();
        chk("R6 pipelined deselect blanks one edge later", a_drive, a_rdata, 1'b0, '0);
        a_rd(8'h10);
        chk("R7 no drive during reactivating read", a_drive, a_rdata, 1'b0, '0);
        a_idle();
        chk("R7 drive after one selected cycle", a_drive, a_rdata, 1'b1, 9'h155);
        a_idle();
        a_pipe = 1'b0;
    endtask

    task automatic t_select();
        a_wr(8'h20, 9'h011);
        for (int i = 0; i < 3; i++) begin
            a_cyc(i != 1, i == 0, 1'b0, 8'h20, 9'h1FF);
            a_cyc(i != 1, i == 0, 1'b1, 8'h20, '0);
            chk("R5 unselected read not driven", a_drive, a_rdata, 1'b0, '0);
            a_rd(8'h20);
            chk("R5 unselected write ignored", a_drive, a_rdata, 1'b1, 9'h011);
        end
        a_idle();
    endtask

    task automatic t_oe();
        a_oe_n = 1'b1;
        a_rd(8'h10);
        chk("R8 oe_n high blanks output", a_drive, a_rdata, 1'b0, '0);
        a_oe_n = 1'b0;
        #1;
        chk("R8 oe_n low restores without edge", a_drive, a_rdata, 1'b1, 9'h155);
        a_idle();
    endtask

    task automatic t_dual();
        fork
            a_wr(8'h30, 9'h123);
            b_wr(8'h31, 9'h0F0);
        join
        fork
            a_idle();
            b_idle();
        join
        fork
            begin
                a_rd(8'h31);
                chk("R9 port A reads word written by B", a_drive, a_rdata, 1'b1, 9'h0F0);
            end
            begin
                b_rd(8'h30);
                chk("R9 port B reads word written by A", b_drive, b_rdata, 1'b1, 9'h123);
            end
        join
        fork
            a_idle();
            b_idle();
        join
    endtask

    task automatic t_rbw();
        a_wr(8'h40, 9'h005);
        a_idle();
        @(negedge clk_a);
        fork
            begin
                a_wr(8'h40, 9'h1A5);
                a_idle();
            end
            begin
                b_rd(8'h40);
                chk("R11 other port sees old word before commit", b_drive, b_rdata, 1'b1, 9'h005);
                b_rd(8'h40);
                chk("R11 other port sees new word after commit", b_drive, b_rdata, 1'b1, 9'h1A5);
                b_idle();
            end
        join
    endtask

    task automatic t_modes();
        a_pipe = 1'b1;
        b_pipe = 1'b0;
        fork
            begin
                a_idle();
                a_rd(8'h30);
                chk("R12 pipelined port A waits", a_drive, a_rdata, 1'b0, '0);
                a_idle();
                chk("R12 pipelined port A delivers", a_drive, a_rdata, 1'b1, 9'h123);
                a_idle();
            end
            begin
                b_idle();
                b_rd(8'h30);
                chk("R12 flow port B delivers at once", b_drive, b_rdata, 1'b1, 9'h123);
                b_idle();
                chk("R12 flow port B blanks", b_drive, b_rdata, 1'b0, '0);
            end
        join
        a_pipe = 1'b0;
    endtask

    task automatic t_reactivate_b();
        b_pipe = 1'b1;
        b_idle();
        b_idle();
        b_rd(8'h31);
        chk("R7 port B no drive on reactivating read", b_drive, b_rdata, 1'b0, '0);
        b_idle();
        chk("R7 port B drives after one selected cycle", b_drive, b_rdata, 1'b1, 9'h0F0);
        b_idle();
        b_pipe = 1'b0;
    endtask

    initial begin
        t_reset();
        t_flow();
        t_pipe();
        t_select();
        t_oe();
        t_dual();
        t_rbw();
        t_modes();
        t_reactivate_b();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=hung expected=completed");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule